// File: doc/BRIEF.md
# Framed Embedded-Clock Word Serializer

This block turns a 10-bit parallel word into a 12-bit serial frame on a single output wire. It captures one word in each period of a slower reference clock. Every frame starts with a high marker bit and ends with a low marker bit. Because of these two bits, the stream changes level at least once per frame, so a receiver can recover the reference timing from the data alone. A control block can also switch the serializer into a synchronisation mode. In that mode each frame is a fixed half-ones, half-zeros pattern, and the parallel word has no effect.

The whole block runs on one serial bit clock. This clock runs at twelve times the reference rate. The reference clock arrives as an ordinary input and is sampled on the bit clock. An edge-select input chooses which transition of the reference clock captures the word. The first transition seen after that choice also re-aligns the 0..11 bit counter, and the frame boundary is tied to that counter. An output-enable input switches the drive indicator with no clock edge involved. Frame generation carries on while the indicator is off, so the bit timing never shifts.

Top module: `framed_serializer`

## Requirements
- R1: A bit counter counts 0 to 11 and wraps. A new frame is loaded at each wrap, so consecutive frame starts are exactly 12 bit clocks apart while the reference period is 12 bit clocks.
- R2: Serial bit 0 of every frame is a 1 (start marker), and serial bit 11 is a 0 (stop marker).
- R3: In data mode, serial bits 1..10 carry the captured word least significant bit first: word bit k appears at serial position k+1.
- R4: When sync_mode is high at the wrap, the frame is six 1s followed by six 0s, whatever data_in holds.
- R5: With edge_sel high, the word is captured on the first bit-clock edge at which ref_clk is seen high after being low. With edge_sel low, it is captured on the first edge at which ref_clk is seen low after being high.
- R6: ser_oe follows out_en with no clock delay once the first frame has been loaded. The serial stream keeps its timing and content while out_en is low.
- R7: The start marker of a word is on ser_out from the second bit-clock edge after its capture edge. Its serial bit k is on ser_out after edge k+2.
- R8: While rst_n is low, and after reset until the first frame has been loaded, ser_out is 0 and ser_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, twelve times the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled on clk |
| edge_sel | input | 1 | 1: rising reference edge captures, 0: falling |
| sync_mode | input | 1 | 1: send the synchronisation pattern, 0: send data |
| data_in | input | 10 | Parallel word to serialize |
| out_en | input | 1 | Drive enable for the serial output |
| ser_out | output | 1 | Serial frame stream |
| ser_oe | output | 1 | Output drive indicator (0 means high impedance) |

## Verification
Two things can fall on the same bit-clock edge: a word capture and the reload at a counter wrap. The bench's reference clock puts each capture edge one cycle before the wrap. It changes the word in mid-half of the reference period, and it flips edge_sel during the run. A capture on the wrong edge, or one clocked together with the reload, therefore shows up as the wrong recovered word. The out_en toggles also land in the middle of frames. The bench deserializes the stream from the known capture edge and checks the start, stop and payload of every frame. It also checks that ser_oe changes within the same cycle as out_en.

// File: rtl/ser_pkg.sv
// Shared types for the framed serializer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ser_pkg;

    // What the next frame carries.
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_SYNC = 1'b1
    } frame_kind_e;

endpackage

// File: rtl/ser_edge_capture.sv
// Reference-edge capture.
// Samples ref_clk on the bit clock and detects the transition chosen by
// edge_sel, then latches the parallel word on that edge.
// Assumes ref_clk is synchronous to clk, or already synchronised.
module ser_edge_capture #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              edge_sel,
    input  logic [DATA_W-1:0] data_in,
    output logic              capture_o,
    output logic [DATA_W-1:0] word_o
);

    logic ref_q;
    logic rise_w;
    logic fall_w;

    // Keep last cycle's reference level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_clk;
    end

    // Pick the selected transition.
    always_comb begin
        rise_w    = ref_clk & ~ref_q;
        fall_w    = ~ref_clk & ref_q;
        capture_o = edge_sel ? rise_w : fall_w;
    end

    // Latch the parallel word on the selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_o <= '0;
        else if (capture_o) word_o <= data_in;
    end

    a_r5_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> (word_o == $past(data_in)));

    a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_o |=> $stable(word_o));

endmodule

// File: rtl/ser_bit_timer.sv
// Bit position counter.
// Counts 0..FRAME_W-1 and wraps. A capture forces it to the last
// position, so the next edge is the frame boundary.
// Assumes the reference period equals FRAME_W bit clocks once locked.
module ser_bit_timer #(
    parameter int unsigned FRAME_W = 12,
    parameter int unsigned CNT_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign_i,
    output logic [CNT_W-1:0] bit_idx_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    // The frame boundary falls on the last position.
    always_comb wrap_o = (bit_idx_o == LAST);

    // Advance, wrap, or re-align to the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         bit_idx_o <= '0;
        else if (realign_i) bit_idx_o <= LAST;
        else if (wrap_o)    bit_idx_o <= '0;
        else                bit_idx_o <= bit_idx_o + 1'b1;
    end

    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx_o <= LAST);

    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !realign_i) |=> (bit_idx_o == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_o && !realign_i) |=> (bit_idx_o == $past(bit_idx_o) + 1'b1));

endmodule

// File: rtl/ser_frame_shifter.sv
// Frame assembly and shift-out.
// At each wrap it loads either {stop, word, start} or the sync pattern.
// It then shifts one bit per clock, start marker first, through an output register.
// A re-align clears the register, so a cut-short frame ends low.
// Assumes kind_i and word_i are stable at the wrap edge.
module ser_frame_shifter
    import ser_pkg::*;
#(
    parameter int unsigned DATA_W  = 10,
    parameter int unsigned FRAME_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic              realign_i,
    input  frame_kind_e       kind_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              ser_o,
    output logic              valid_o
);

    localparam int unsigned ONES_W = FRAME_W / 2;

    logic [FRAME_W-1:0] sync_pat;
    logic [FRAME_W-1:0] data_frame;
    logic [FRAME_W-1:0] shreg;

    // Sync pattern: lower half ones (sent first), upper half zeros.
    for (genvar i = 0; i < FRAME_W; i++) begin : g_sync
        assign sync_pat[i] = (i < ONES_W);
    end

    // Data frame: start marker at bit 0, LSB of the word next, stop last.
    always_comb data_frame = {1'b0, word_i, 1'b1};

    // Load at the boundary, clear on re-align, otherwise shift down.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (wrap_i)    shreg <= (kind_i == KIND_SYNC) ? sync_pat : data_frame;
        else if (realign_i) shreg <= '0;
        else                shreg <= shreg >> 1;
    end

    // Register the serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ser_o <= 1'b0;
        else        ser_o <= shreg[0];
    end

    // Note that a first frame exists.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_o <= 1'b0;
        else if (wrap_i) valid_o <= 1'b1;
    end

    a_r4_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && kind_i == KIND_SYNC) |=> (shreg == sync_pat));

    a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && kind_i == KIND_DATA) |=> (shreg[FRAME_W-2:1] == $past(word_i)));

    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

endmodule

// File: rtl/framed_serializer.sv
// Framed embedded-clock word serializer (top).
// Captures a word on the selected reference edge and sends it as a
// 12-bit frame: start 1, ten data bits LSB first, stop 0. It can send a
// six-ones/six-zeros sync frame instead. out_en gates the drive
// indicator with no clock involved.
// Assumes clk runs at FRAME_W times the reference rate.
module framed_serializer
    import ser_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              edge_sel,
    input  logic              sync_mode,
    input  logic [DATA_W-1:0] data_in,
    input  logic              out_en,
    output logic              ser_out,
    output logic              ser_oe
);

    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);

    logic              capture;
    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  bit_idx;
    logic              wrap;
    logic              valid;
    frame_kind_e       kind;

    // Mode input picks the frame kind.
    always_comb kind = sync_mode ? KIND_SYNC : KIND_DATA;

    ser_edge_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .edge_sel  (edge_sel),
        .data_in   (data_in),
        .capture_o (capture),
        .word_o    (word)
    );

    ser_bit_timer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign_i (capture),
        .bit_idx_o (bit_idx),
        .wrap_o    (wrap)
    );

    ser_frame_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap),
        .realign_i (capture),
        .kind_i    (kind),
        .word_i    (word),
        .ser_o     (ser_out),
        .valid_o   (valid)
    );

    // Drive indicator: no clock in the path from out_en.
    always_comb ser_oe = out_en & valid;

    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && bit_idx == CNT_W'(1)) |-> ser_out);

    a_r2_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == '0) |-> !ser_out);

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture, 3) |-> ser_out);

    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!ser_out && !ser_oe));

endmodule

// File: tb/framed_serializer_tb.sv
`timescale 1ns/1ps
module framed_serializer_tb;

    localparam int DW = 10;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic          edge_sel = 1'b1;
    logic          sync_mode = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          out_en = 1'b1;
    logic          ser_out;
    logic          ser_oe;

    framed_serializer #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .edge_sel(edge_sel),
        .sync_mode(sync_mode), .data_in(data_in), .out_en(out_en),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always #2.5 clk = ~clk;

    int unsigned tick = 0;
    always @(posedge clk) tick <= tick + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int unsigned   start;
        logic          sync;
        logic [DW-1:0] word;
    } exp_t;
    exp_t pend[$];
    logic samp [64];

    // Expected frame from the requirements: R2 markers, R3 order, R4 pattern.
    function automatic logic [FW-1:0] exp_frame(logic sync, logic [DW-1:0] w);
        logic [FW-1:0] f;
        if (sync) begin
            for (int i = 0; i < FW; i++) f[i] = (i < 6);
        end else begin
            f = {1'b0, w, 1'b1};
        end
        return f;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at tick %0d", req, act, expv, tick);
        end
    endtask

    // Deserializer: collect samples and judge each frame when complete.
    always @(negedge clk) begin
        logic [FW-1:0] got;
        logic [FW-1:0] want;
        samp[tick % 64] = ser_out;
        while (pend.size() > 0 && pend[0].start + FW - 1 <= tick) begin
            if (pend[0].start + FW - 1 == tick) begin
                for (int k = 0; k < FW; k++) got[k] = samp[(pend[0].start + k) % 64];
                want = exp_frame(pend[0].sync, pend[0].word);
                if (pend[0].sync) begin
                    check(got == want, "R4", got, want);
                end else begin
                    check(got[0] == 1'b1, "R2", got[0], 1);
                    check(got[FW-1] == 1'b0, "R2", got[FW-1], 0);
                    check(got == want, "R3", got, want);
                end
                // R7 and R1: the bit before the start is the previous stop/idle low.
                check(samp[(pend[0].start + 63) % 64] == 1'b0, "R7", samp[(pend[0].start + 63) % 64], 0);
            end
            void'(pend.pop_front());
        end
    end

    // Run reference periods; push expectations at the selected edge.
    task automatic run_periods(int n, int sync_pct, bit push_en, int fixed_word);
        for (int p = 0; p < n; p++) begin
            for (int ph = 0; ph < FW; ph++) begin
                @(negedge clk);
                if (ph == 0) ref_clk = 1'b1;
                if (ph == 6) ref_clk = 1'b0;
                if ((ph == 0 && edge_sel) || (ph == 6 && !edge_sel)) begin
                    if (push_en) pend.push_back('{tick + 3, sync_mode, data_in});
                end
                if (ph == 3) sync_mode = (($urandom % 100) < sync_pct);
                if (ph == 3 || ph == 9) begin
                    if (fixed_word >= 0 && ph == (edge_sel ? 9 : 3)) data_in = DW'(fixed_word);
                    else data_in = DW'($urandom);
                end
                if (ph == 4 && ($urandom % 4) == 0) begin
                    out_en = ~out_en;
                    #0.5;
                    // R6: indicator follows out_en inside the same cycle.
                    check(ser_oe == out_en, "R6", ser_oe, out_en);
                end
            end
        end
    endtask

    task automatic switch_edge(bit es);
        pend.delete();
        @(negedge clk);
        edge_sel = es;
        run_periods(2, 0, 0, -1);
    endtask

    initial begin
        void'($urandom(32'h5E41));
        repeat (5) @(negedge clk);
        // R8: reset state.
        check(ser_out == 1'b0, "R8", ser_out, 0);
        check(ser_oe == 1'b0, "R8", ser_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_oe == 1'b0, "R8", ser_oe, 0);
        check(ser_out == 1'b0, "R8", ser_out, 0);

        // R5 rising edge, R1 continuous frames.
        edge_sel = 1'b1;
        run_periods(2, 0, 0, -1);
        run_periods(40, 0, 1, -1);
        run_periods(2, 0, 1, 10'h3FF);
        run_periods(2, 0, 1, 10'h000);
        run_periods(2, 0, 1, 10'h155);
        run_periods(2, 0, 1, 10'h2AA);
        // R4 sync frames, data still changing.
        run_periods(6, 100, 1, -1);
        run_periods(30, 30, 1, -1);

        // R5 falling edge.
        switch_edge(1'b0);
        run_periods(40, 0, 1, -1);
        run_periods(2, 0, 1, 10'h001);
        run_periods(2, 0, 1, 10'h200);
        run_periods(20, 40, 1, -1);

        // Back to rising.
        switch_edge(1'b1);
        run_periods(20, 20, 1, -1);
        run_periods(2, 0, 0, -1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule